// File: doc/BRIEF.md
# Automatic Port Scan Engine

This block steps a four-way port selector through a set of enabled ports, one after another, and listens on each for a carrier. A one-cycle start pulse launches a pass. The engine asks the selector for the lowest enabled port. It waits until the selector reports that switching is done. It then holds the port for a dwell and moves on. After the last enabled port it returns to idle.

The dwell is set by one of four modes. In manual mode the dwell lasts until software strobes an index input. The timed modes count bit-period ticks: a single tick, sixteen ticks, or a 12-bit user multiplier. A carrier seen on the current port can end the dwell early or can be allowed to run its full length. Each port has a sticky result flag that records a detection. The flags survive the end of the pass and are cleared only by the next start.

Top module: `port_scan_engine`

## Requirements
- R1: After reset, `scanning`, `port_req_valid` and all of `port_found` are 0, and `listen_port` is 0.
- R2: A start pulse seen while idle with a nonzero mask raises `scanning` in the next cycle. In that cycle `port_req_valid` pulses for one cycle with `port_req` and `listen_port` equal to the lowest port whose mask bit is set. A start pulse seen while scanning has no effect.
- R3: Mask bit n enables port n. Ports are visited in ascending order and disabled ports are skipped. When the last enabled port's dwell ends, `scanning` drops in the same cycle that a next request would otherwise have appeared.
- R4: After a request, dwell counting starts only once `sel_busy` is low. Listening starts two cycles after the request when `sel_busy` stays low. Ticks that arrive while the selector is busy are not counted.
- R5: `dwell_mode` 1 ends the dwell on the first `bit_tick` while listening. `dwell_mode` 2 ends it on the 16th tick.
- R6: `dwell_mode` 3 ends the dwell after `dwell_mult` ticks, and a `dwell_mult` of 0 means 4096 ticks.
- R7: `dwell_mode` 0 (manual) ignores ticks. The dwell ends when `index_strobe` is high while listening.
- R8: A carrier while listening with `full_dwell` 0 ends the dwell at once in manual mode. In the timed modes it does so only when `check_all` is 1. With `full_dwell` 1, the port is held for the rest of its dwell.
- R9: `carrier_det` high while listening on port n sets `port_found[n]`. The bit stays set, even after the pass ends, until the next accepted start clears all flags. A carrier while idle changes nothing.
- R10: A start with a zero mask clears the flags but issues no request, does not raise `scanning`, and leaves `listen_port` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_mask | input | 4 | Port enable mask, bit n for port n |
| start | input | 1 | One-cycle pulse that begins a pass |
| index_strobe | input | 1 | Manual-mode advance pulse |
| dwell_mode | input | 2 | 0 manual, 1 one tick, 2 sixteen ticks, 3 user multiplier |
| dwell_mult | input | 12 | User tick multiplier, 0 means 4096 |
| full_dwell | input | 1 | Hold the port for the whole dwell after a detection |
| check_all | input | 1 | Allow early advance on detection in timed modes |
| bit_tick | input | 1 | One-cycle pulse per bit period |
| carrier_det | input | 1 | Carrier present on the listened port |
| sel_busy | input | 1 | Selector is still switching |
| port_req_valid | output | 1 | One-cycle request to the selector |
| port_req | output | 2 | Port being requested |
| scanning | output | 1 | A pass is in progress |
| listen_port | output | 2 | Port currently connected |
| port_found | output | 4 | Sticky detection flags, bit n for port n |

## Verification
The bench counts ticks to the exact expiry edge in every timed mode. A counter that is off by one would advance a tick early or late. A multiplier of 0 taken literally would end the dwell at once instead of at tick 4096. Holding `sel_busy` high while ticks arrive exposes a design that starts its dwell before the selector settles. Two further cases target the flags: an idle carrier after a pass, and a restart that must wipe earlier results. A zero-mask start catches a design that raises `scanning` or issues a stray request.

// File: rtl/scan_pkg.sv
package scan_pkg;
  typedef enum logic [1:0] {
    DW_MANUAL  = 2'd0,
    DW_ONE     = 2'd1,
    DW_SIXTEEN = 2'd2,
    DW_USER    = 2'd3
  } dwell_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_REQ    = 2'd1,
    ST_SETTLE = 2'd2,
    ST_LISTEN = 2'd3
  } scan_state_e;
endpackage

// File: rtl/scan_rst_sync.sv
module scan_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/scan_port_picker.sv
// Finds the lowest enabled port, either from port 0 or above the current one.
module scan_port_picker #(
  parameter int NUM_PORTS = 4,
  localparam int PORT_W = $clog2(NUM_PORTS)
) (
  input  logic [NUM_PORTS-1:0] mask,
  input  logic [PORT_W-1:0]    cur,
  input  logic                 from_first,
  output logic                 found,
  output logic [PORT_W-1:0]    next
);
  logic [NUM_PORTS-1:0] cand;

  for (genvar gi = 0; gi < NUM_PORTS; gi++) begin : g_cand
    assign cand[gi] = mask[gi] && (from_first || (PORT_W'(gi) > cur));
  end

  always_comb begin
    found = 1'b0;
    next  = '0;
    for (int i = NUM_PORTS - 1; i >= 0; i--) begin
      if (cand[i]) begin
        found = 1'b1;
        next  = PORT_W'(i);
      end
    end
  end
endmodule

// File: rtl/scan_dwell_timer.sv
// Counts bit ticks and flags the tick that ends the dwell.
module scan_dwell_timer
  import scan_pkg::*;
#(
  parameter int MULT_W    = 12,
  parameter int LONG_BITS = 16,
  localparam int CNT_W = MULT_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              tick,
  input  logic [1:0]        mode,
  input  logic [MULT_W-1:0] mult,
  output logic              expire
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] target;
  logic             manual;
  logic             cnt_en;
  logic             hit;

  assign manual = (dwell_mode_e'(mode) == DW_MANUAL);

  always_comb begin
    case (dwell_mode_e'(mode))
      DW_ONE:     target = CNT_W'(1);
      DW_SIXTEEN: target = CNT_W'(LONG_BITS);
      DW_USER:    target = (mult == '0) ? (CNT_W'(1) << MULT_W) : {1'b0, mult};
      default:    target = '0;
    endcase
  end

  assign hit    = (cnt_q + CNT_W'(1)) == target;
  assign expire = tick && !manual && hit;
  assign cnt_en = clr || (tick && !manual);

  always_comb begin
    if (clr || expire) cnt_d = '0;
    else               cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/scan_result_flags.sv
// Sticky per-port detection flags, cleared together.
module scan_result_flags #(
  parameter int NUM_PORTS = 4,
  localparam int PORT_W = $clog2(NUM_PORTS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 set_en,
  input  logic [PORT_W-1:0]    set_idx,
  output logic [NUM_PORTS-1:0] flags
);
  for (genvar gi = 0; gi < NUM_PORTS; gi++) begin : g_flag
    logic hit;
    logic en;
    logic d;
    assign hit = set_en && (set_idx == PORT_W'(gi));
    assign en  = clr || hit;
    assign d   = !clr;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  flags[gi] <= 1'b0;
      else if (en) flags[gi] <= d;
    end
  end
endmodule

// File: rtl/port_scan_engine.sv
module port_scan_engine
  import scan_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int MULT_W    = 12,
  parameter int LONG_BITS = 16,
  localparam int PORT_W = $clog2(NUM_PORTS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PORTS-1:0] port_mask,
  input  logic                 start,
  input  logic                 index_strobe,
  input  logic [1:0]           dwell_mode,
  input  logic [MULT_W-1:0]    dwell_mult,
  input  logic                 full_dwell,
  input  logic                 check_all,
  input  logic                 bit_tick,
  input  logic                 carrier_det,
  input  logic                 sel_busy,
  output logic                 port_req_valid,
  output logic [PORT_W-1:0]    port_req,
  output logic                 scanning,
  output logic [PORT_W-1:0]    listen_port,
  output logic [NUM_PORTS-1:0] port_found
);
  logic rst_n_i;

  scan_state_e          state_q, state_d;
  logic [PORT_W-1:0]    port_q, port_d;
  logic [NUM_PORTS-1:0] mask_q, mask_d;

  logic                 idle, listening, manual;
  logic [NUM_PORTS-1:0] pick_mask;
  logic                 pick_found;
  logic [PORT_W-1:0]    pick_next;
  logic                 expire, early, advance;
  logic                 clr_found, set_found;

  scan_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  assign idle      = (state_q == ST_IDLE);
  assign listening = (state_q == ST_LISTEN);
  assign manual    = (dwell_mode_e'(dwell_mode) == DW_MANUAL);
  assign pick_mask = idle ? port_mask : mask_q;

  scan_port_picker #(.NUM_PORTS(NUM_PORTS)) u_pick (
    .mask       (pick_mask),
    .cur        (port_q),
    .from_first (idle),
    .found      (pick_found),
    .next       (pick_next)
  );

  scan_dwell_timer #(.MULT_W(MULT_W), .LONG_BITS(LONG_BITS)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n_i),
    .clr    (!listening),
    .tick   (bit_tick && listening),
    .mode   (dwell_mode),
    .mult   (dwell_mult),
    .expire (expire)
  );

  // Early exit on a carrier: manual mode needs only full_dwell clear.
  assign early   = carrier_det && !full_dwell && (manual || check_all);
  assign advance = listening && (expire || (manual && index_strobe) || early);

  assign clr_found = idle && start;
  assign set_found = listening && carrier_det;

  scan_result_flags #(.NUM_PORTS(NUM_PORTS)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .clr     (clr_found),
    .set_en  (set_found),
    .set_idx (port_q),
    .flags   (port_found)
  );

  always_comb begin
    state_d = state_q;
    port_d  = port_q;
    mask_d  = mask_q;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          mask_d = port_mask;
          if (pick_found) begin
            state_d = ST_REQ;
            port_d  = pick_next;
          end
        end
      end
      ST_REQ: state_d = ST_SETTLE;
      ST_SETTLE: begin
        if (!sel_busy) state_d = ST_LISTEN;
      end
      ST_LISTEN: begin
        if (advance) begin
          if (pick_found) begin
            state_d = ST_REQ;
            port_d  = pick_next;
          end else begin
            state_d = ST_IDLE;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      state_q <= ST_IDLE;
      port_q  <= '0;
      mask_q  <= '0;
    end else begin
      state_q <= state_d;
      port_q  <= port_d;
      mask_q  <= mask_d;
    end
  end

  assign port_req_valid = (state_q == ST_REQ);
  assign port_req       = port_q;
  assign scanning       = !idle;
  assign listen_port    = port_q;
endmodule

// File: rtl/port_scan_engine_chk.sv
module port_scan_engine_chk #(
  parameter int NUM_PORTS = 4,
  localparam int PORT_W = $clog2(NUM_PORTS)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 start,
  input logic [NUM_PORTS-1:0] port_mask,
  input logic                 carrier_det,
  input logic                 port_req_valid,
  input logic [PORT_W-1:0]    port_req,
  input logic                 scanning,
  input logic [NUM_PORTS-1:0] port_found,
  input logic [NUM_PORTS-1:0] mask_q
);
  a_r2_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    port_req_valid |=> !port_req_valid);

  a_r2_req_scanning: assert property (@(posedge clk) disable iff (!rst_n)
    port_req_valid |-> scanning);

  a_r3_req_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    port_req_valid |-> mask_q[port_req]);

  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(port_found) & ~port_found)) |-> $past(start));

  a_r9_flag_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (|(port_found & ~$past(port_found))) |-> $past(carrier_det));

  a_r10_empty_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !scanning && (port_mask == '0)) |=> !scanning);
endmodule

bind port_scan_engine port_scan_engine_chk #(.NUM_PORTS(NUM_PORTS)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n_i),
  .start          (start),
  .port_mask      (port_mask),
  .carrier_det    (carrier_det),
  .port_req_valid (port_req_valid),
  .port_req       (port_req),
  .scanning       (scanning),
  .port_found     (port_found),
  .mask_q         (mask_q)
);

// File: tb/port_scan_engine_bench.sv
module port_scan_engine_bench;
  logic        clk;
  logic        rst_n;
  logic [3:0]  port_mask;
  logic        start;
  logic        index_strobe;
  logic [1:0]  dwell_mode;
  logic [11:0] dwell_mult;
  logic        full_dwell;
  logic        check_all;
  logic        bit_tick;
  logic        carrier_det;
  logic        sel_busy;
  logic        port_req_valid;
  logic [1:0]  port_req;
  logic        scanning;
  logic [1:0]  listen_port;
  logic [3:0]  port_found;

  int checks;
  int failures;

  port_scan_engine u_port_scan_engine (
    .clk            (clk),
    .rst_n          (rst_n),
    .port_mask      (port_mask),
    .start          (start),
    .index_strobe   (index_strobe),
    .dwell_mode     (dwell_mode),
    .dwell_mult     (dwell_mult),
    .full_dwell     (full_dwell),
    .check_all      (check_all),
    .bit_tick       (bit_tick),
    .carrier_det    (carrier_det),
    .sel_busy       (sel_busy),
    .port_req_valid (port_req_valid),
    .port_req       (port_req),
    .scanning       (scanning),
    .listen_port    (listen_port),
    .port_found     (port_found)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic start_pulse(input logic [3:0] m);
    port_mask = m;
    start = 1'b1;
    cyc();
    start = 1'b0;
  endtask

  task automatic tick_n(input int n);
    bit_tick = 1'b1;
    repeat (n) cyc();
    bit_tick = 1'b0;
  endtask

  task automatic expect_req(input int p, input string tag);
    check(tag, "req_valid", int'(port_req_valid), 1);
    check(tag, "req_port", int'(port_req), p);
    check(tag, "listen_port", int'(listen_port), p);
    check(tag, "scanning", int'(scanning), 1);
    cyc();
    cyc();
  endtask

  task automatic expect_hold(input int p, input string tag);
    check(tag, "no_req", int'(port_req_valid), 0);
    check(tag, "listen_hold", int'(listen_port), p);
    check(tag, "still_scanning", int'(scanning), 1);
  endtask

  task automatic expect_end(input string tag);
    check(tag, "scan_done", int'(scanning), 0);
    check(tag, "no_req_at_end", int'(port_req_valid), 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    port_mask = 4'hF; start = 0; index_strobe = 0; dwell_mode = 2'd1;
    dwell_mult = 12'd1; full_dwell = 0; check_all = 0; bit_tick = 0;
    carrier_det = 0; sel_busy = 0;
    repeat (3) cyc();
    rst_n = 1'b1;
    repeat (4) cyc();
    check("R1", "scanning", int'(scanning), 0);
    check("R1", "req_valid", int'(port_req_valid), 0);
    check("R1", "found", int'(port_found), 0);
    check("R1", "listen_port", int'(listen_port), 0);
  endtask

  task automatic t_one_tick_all();
    dwell_mode = 2'd1;
    start_pulse(4'b1111);
    expect_req(0, "R2");
    for (int p = 1; p < 4; p++) begin
      tick_n(1);
      expect_req(p, "R3");
    end
    tick_n(1);
    expect_end("R3");
  endtask

  task automatic t_mask_skip();
    dwell_mode = 2'd1;
    start_pulse(4'b1010);
    expect_req(1, "R3");
    tick_n(1);
    expect_req(3, "R3");
    tick_n(1);
    expect_end("R3");
  endtask

  task automatic t_sixteen();
    dwell_mode = 2'd2;
    start_pulse(4'b0001);
    expect_req(0, "R5");
    tick_n(15);
    expect_hold(0, "R5");
    tick_n(1);
    expect_end("R5");
  endtask

  task automatic t_user_mult();
    dwell_mode = 2'd3;
    dwell_mult = 12'd5;
    start_pulse(4'b0011);
    expect_req(0, "R6");
    tick_n(4);
    expect_hold(0, "R6");
    tick_n(1);
    expect_req(1, "R6");
    dwell_mult = 12'd0;
    tick_n(4095);
    expect_hold(1, "R6");
    tick_n(1);
    expect_end("R6");
  endtask

  task automatic t_manual();
    dwell_mode = 2'd0;
    full_dwell = 0;
    check_all = 0;
    start_pulse(4'b0011);
    expect_req(0, "R7");
    tick_n(20);
    expect_hold(0, "R7");
    start_pulse(4'b0011);
    expect_hold(0, "R2");
    index_strobe = 1'b1;
    cyc();
    index_strobe = 1'b0;
    expect_req(1, "R7");
    carrier_det = 1'b1;
    cyc();
    carrier_det = 1'b0;
    expect_end("R8");
    check("R9", "manual_found", int'(port_found), 4'b0010);
  endtask

  task automatic t_detect();
    dwell_mode = 2'd2;
    full_dwell = 0;
    check_all = 1;
    start_pulse(4'b1111);
    check("R9", "cleared_on_start", int'(port_found), 0);
    expect_req(0, "R8");
    carrier_det = 1'b1;
    cyc();
    carrier_det = 1'b0;
    check("R9", "found_p0", int'(port_found), 4'b0001);
    expect_req(1, "R8");
    full_dwell = 1;
    carrier_det = 1'b1;
    cyc();
    carrier_det = 1'b0;
    expect_hold(1, "R8");
    check("R9", "found_p1", int'(port_found), 4'b0011);
    tick_n(16);
    expect_req(2, "R8");
    full_dwell = 0;
    check_all = 0;
    carrier_det = 1'b1;
    cyc();
    carrier_det = 1'b0;
    expect_hold(2, "R8");
    tick_n(16);
    expect_req(3, "R8");
    tick_n(16);
    expect_end("R8");
    check("R9", "sticky_after_pass", int'(port_found), 4'b0111);
    carrier_det = 1'b1;
    repeat (3) cyc();
    carrier_det = 1'b0;
    check("R9", "idle_carrier_ignored", int'(port_found), 4'b0111);
    dwell_mode = 2'd1;
    start_pulse(4'b1111);
    check("R9", "cleared_on_restart", int'(port_found), 0);
    expect_req(0, "R9");
    for (int p = 1; p < 4; p++) begin
      tick_n(1);
      expect_req(p, "R9");
    end
    tick_n(1);
    expect_end("R9");
  endtask

  task automatic t_busy();
    dwell_mode = 2'd1;
    sel_busy = 1'b1;
    start_pulse(4'b0011);
    check("R4", "req_valid", int'(port_req_valid), 1);
    check("R4", "req_port", int'(port_req), 0);
    cyc();
    tick_n(3);
    expect_hold(0, "R4");
    sel_busy = 1'b0;
    cyc();
    tick_n(1);
    expect_req(1, "R4");
    tick_n(1);
    expect_end("R4");
  endtask

  task automatic t_empty();
    start_pulse(4'b0001);
    expect_req(0, "R10");
    carrier_det = 1'b1;
    cyc();
    carrier_det = 1'b0;
    dwell_mode = 2'd1;
    tick_n(1);
    expect_end("R10");
    check("R10", "found_before", int'(port_found), 4'b0001);
    start_pulse(4'b0000);
    check("R10", "no_scan", int'(scanning), 0);
    check("R10", "no_req", int'(port_req_valid), 0);
    check("R10", "flags_cleared", int'(port_found), 0);
    check("R10", "port_kept", int'(listen_port), 0);
    cyc();
    check("R10", "still_idle", int'(scanning), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    checks = 0;
    failures = 0;
    t_reset();
    t_one_tick_all();
    t_mask_skip();
    t_sixteen();
    t_user_mult();
    t_manual();
    t_detect();
    t_busy();
    t_empty();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule